// File: doc/BRIEF.md
# Shared-Interrupt Match Channel Bank with Counter Sharing and Snapshot

Eight counter/compare channels, numbered 4 to 11 at the system level and 0 to 7 inside the block, signal through one shared interrupt line. Each channel has three registers: a counter, a compare value and a control word. The control word sets five things: which of eight tick-enable inputs drives the counter, whether the channel compares against its own counter or a shared one, whether the compared counter returns to zero on a match, whether the channel re-arms after a match, and whether reading the counter also captures a neighbour's counter. The block does not make the tick rates. The caller supplies one tick-enable strobe per source, and a parameter mask marks which sources are present.

Each channel runs a two-state controller. In CH_DISARMED the channel cannot match. In CH_ARMED a match is possible. Three transitions exist. A write to the compare register moves the channel from DISARMED to ARMED (ARM). A match with periodic mode clear moves it from ARMED to DISARMED (FIRE_ONCE). A match with periodic mode set keeps it in ARMED (FIRE_REPEAT). Every match whose enable bit is set sets a status bit. The interrupt stays high while any status bit is set.

Software uses a simple register bus. A write takes effect on the clock edge where `wr_en` is high. A read returns `rdata` on the edge where `rd_en` is high.

Top module: `match_bank`

## Requirements
- R1: After reset the following are all zero: counters, compare values, control words, status, enables and snapshot. Every channel is in CH_DISARMED and `irq` is low.
- R2: Address map, with `addr[2:0]` selecting the channel:
  - 0x00+i is the compare value.
  - 0x08+i is the counter.
  - 0x10+i is the control word.
  - 0x18 is status and 0x19 is enable. Both use bits 11:4, with bit 4+i for channel i.
  - 0x1A is the snapshot.
  A write lands on the edge where `wr_en` is high. `rdata` is registered on the edge where `rd_en` is high.
- R3: Counter i counts up by one on an edge where the selected source is both present and strobed. The source is `tick_src[ctrl[2:0]]`, and it is present if it is set in `SRC_LIVE`. Source 5 is absent by default, so selecting it stops the counter.
- R4: With control bit 7 set, channel i compares against its own counter. With bit 7 clear, channels 0-3 use counter 0, channels 4-5 use counter 4 and channels 6-7 use counter 6.
- R5: A match occurs when an armed channel's compared counter steps from compare-1 to compare. On that edge, status bit 4+i is set, but only if enable bit 4+i is set.
- R6: With control bit 3 set, a match loads zero into the compared counter instead of the compare value.
- R7: A write to the compare register arms the channel. After a match the channel disarms unless control bit 6 is set, in which case it fires on every later match.
- R8: Control writes keep bits 7:0 for channels 0-3 and bits 9:0 for channels 4-7. Other bits read as zero.
- R9: On channels 4-7, control bit 8 forces source 0, whatever bits 2:0 hold.
- R10: A counter read of channel 5 or 7 with control bit 9 set copies the counter of channel 4 or 6 into the snapshot. The snapshot holds its value until the next capture.
- R11: Writing ones to status bits clears them. `irq` falls only when all status bits are clear. A match sets its status bit even when the same write clears it.
- R12: A write to the counter register loads the counter. The write takes priority over a tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_src | input | 8 | One tick-enable strobe per source |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 5 | Register address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| irq | output | 1 | Shared interrupt, high while any status bit is set |

## Verification
A tick strobe in cycle t updates the counter, the status bit and `irq` on the same edge. The bench drives stimulus at a falling edge and samples at the next falling edge, which falls exactly one register after the stimulus. A read returns data one edge after `rd_en`, and any snapshot capture lands on that same edge. Each read task therefore samples at the falling edge after the strobe. Every expected count is worked out from the number of tick strobes the bench issued.

// File: rtl/tm_pkg.sv
package tm_pkg;
    localparam int NCH = 8;
    localparam int CTRL_W = 10;

    localparam int B_OWN      = 7;
    localparam int B_ZERO     = 3;
    localparam int B_PERIODIC = 6;
    localparam int B_FORCE0   = 8;
    localparam int B_SNAP     = 9;

    typedef enum logic {CH_DISARMED = 1'b0, CH_ARMED = 1'b1} ch_state_e;

    function automatic int share_idx(input int n);
        if (n < 4)      return 0;
        else if (n < 6) return 4;
        else            return 6;
    endfunction
endpackage

// File: rtl/tm_counter.sv
module tm_counter #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          inc,
    input  logic          ld,
    input  logic [CW-1:0] ld_val,
    input  logic          clr,
    output logic [CW-1:0] cnt
);
    always_ff @(posedge clk) begin
        if (!rst_n)   cnt <= '0;
        else if (ld)  cnt <= ld_val;
        else if (clr) cnt <= '0;
        else if (inc) cnt <= cnt + CW'(1);
    end

    a_r3_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!inc && !ld && !clr) |=> $stable(cnt));
endmodule

// File: rtl/tm_channel.sv
module tm_channel import tm_pkg::*; #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] cnt_cmp,
    input  logic          tick_cmp,
    input  logic [CW-1:0] match,
    input  logic          arm,
    input  logic          periodic,
    output logic          hit
);
    ch_state_e st_q, st_d;

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= CH_DISARMED;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            CH_DISARMED: if (arm) st_d = CH_ARMED;
            CH_ARMED:    if (arm) st_d = CH_ARMED;
                         else if (hit && !periodic) st_d = CH_DISARMED;
            default:     st_d = CH_DISARMED;
        endcase
    end

    assign hit = (st_q == CH_ARMED) && tick_cmp && ((cnt_cmp + CW'(1)) == match);

    a_r7_one_shot_disarms: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && !periodic && !arm) |=> (st_q == CH_DISARMED));
endmodule

// File: rtl/match_bank.sv
module match_bank import tm_pkg::*; #(
    parameter int          CW       = 16,
    parameter int          DW       = 32,
    parameter logic [7:0]  SRC_LIVE = 8'hDF
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [7:0]    tick_src,
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic [4:0]    addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    output logic          irq
);
    localparam int SB = 4;

    logic [CTRL_W-1:0] ctrl_q  [NCH];
    logic [CW-1:0]     match_q [NCH];
    logic [CW-1:0]     cnt     [NCH];
    logic [NCH-1:0]    inc, ld, clr, hit, arm, en_q, status_q, clr_req;
    logic [CW-1:0]     snap_q;
    logic              wr_match, wr_cnt, wr_ctrl, wr_stat, wr_en_reg, snap_cap;
    logic [2:0]        sel;

    assign sel       = addr[2:0];
    assign wr_match  = wr_en && addr[4:3] == 2'b00;
    assign wr_cnt    = wr_en && addr[4:3] == 2'b01;
    assign wr_ctrl   = wr_en && addr[4:3] == 2'b10;
    assign wr_stat   = wr_en && addr == 5'h18;
    assign wr_en_reg = wr_en && addr == 5'h19;
    assign clr_req   = wr_stat ? wdata[SB+NCH-1:SB] : '0;
    assign snap_cap  = rd_en && addr[4:3] == 2'b01 && (sel == 3'd5 || sel == 3'd7)
                       && ctrl_q[sel][B_SNAP];

    for (genvar k = 0; k < NCH; k++) begin : g_ch
        localparam int SH = share_idx(k);
        logic [2:0] src;
        if (k >= 4) begin : g_force
            assign src = ctrl_q[k][B_FORCE0] ? 3'd0 : ctrl_q[k][2:0];
        end else begin : g_plain
            assign src = ctrl_q[k][2:0];
        end
        assign inc[k] = tick_src[src] & SRC_LIVE[src];
        assign ld[k]  = wr_cnt && sel == 3'(k);
        assign arm[k] = wr_match && sel == 3'(k);

        tm_counter #(.CW(CW)) u_cnt (
            .clk(clk), .rst_n(rst_n), .inc(inc[k]), .ld(ld[k]),
            .ld_val(wdata[CW-1:0]), .clr(clr[k]), .cnt(cnt[k])
        );

        tm_channel #(.CW(CW)) u_ch (
            .clk(clk), .rst_n(rst_n),
            .cnt_cmp(ctrl_q[k][B_OWN] ? cnt[k] : cnt[SH]),
            .tick_cmp(ctrl_q[k][B_OWN] ? inc[k] : inc[SH]),
            .match(match_q[k]), .arm(arm[k]),
            .periodic(ctrl_q[k][B_PERIODIC]), .hit(hit[k])
        );

        a_r5_status_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(status_q[k]) |-> $past(en_q[k]));
    end

    always_comb begin
        clr = '0;
        for (int n = 0; n < NCH; n++)
            if (hit[n] && ctrl_q[n][B_ZERO])
                clr[ctrl_q[n][B_OWN] ? n : share_idx(n)] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int n = 0; n < NCH; n++) begin
                ctrl_q[n]  <= '0;
                match_q[n] <= '0;
            end
            en_q     <= '0;
            status_q <= '0;
            snap_q   <= '0;
        end else begin
            for (int n = 0; n < NCH; n++) begin
                if (wr_ctrl && sel == 3'(n))
                    ctrl_q[n] <= (n < 4) ? {2'b00, wdata[7:0]} : wdata[CTRL_W-1:0];
                if (arm[n])
                    match_q[n] <= wdata[CW-1:0];
            end
            if (wr_en_reg) en_q <= wdata[SB+NCH-1:SB];
            status_q <= (status_q & ~clr_req) | (hit & en_q);
            if (snap_cap) snap_q <= cnt[sel - 3'd1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rdata <= '0;
        else if (rd_en) begin
            unique case (addr[4:3])
                2'b00: rdata <= DW'(match_q[sel]);
                2'b01: rdata <= DW'(cnt[sel]);
                2'b10: rdata <= DW'(ctrl_q[sel]);
                default: begin
                    if (addr == 5'h18)      rdata <= DW'({status_q, 4'b0000});
                    else if (addr == 5'h19) rdata <= DW'({en_q, 4'b0000});
                    else if (addr == 5'h1A) rdata <= DW'(snap_q);
                    else                    rdata <= '0;
                end
            endcase
        end
    end

    assign irq = |status_q;

    a_r11_clear_all_drops_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stat && (&wdata[SB+NCH-1:SB]) && hit == '0) |=> !irq);
    a_r10_snapshot_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !snap_cap |=> $stable(snap_q));
endmodule

// File: tb/match_bank_bench.sv
module match_bank_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  tick_src = '0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [4:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;
    int          n_chk = 0, n_fail = 0;
    logic [31:0] v;

    always #2 clk = ~clk;

    match_bank u_match_bank (
        .clk(clk), .rst_n(rst_n), .tick_src(tick_src), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk); rd_en = 1'b1; addr = a;
        @(negedge clk); rd_en = 1'b0; d = rdata;
    endtask

    task automatic tick(input logic [7:0] m, input int cnt);
        for (int i = 0; i < cnt; i++) begin
            @(negedge clk); tick_src = m;
            @(negedge clk); tick_src = '0;
        end
    endtask

    initial begin
        #400000;
        n_fail++; n_chk++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check("R1 irq", {31'b0, irq}, 0);
        rd(5'h18, v); check("R1 status", v, 0);
        rd(5'h08, v); check("R1 counter", v, 0);
        rd(5'h1A, v); check("R1 snapshot", v, 0);
        rd(5'h12, v); check("R1 control", v, 0);

        // R3 / R12 counting from source 0, other sources ignored
        wr(5'h10, 32'h80);
        wr(5'h08, 32'h10);
        tick(8'h01, 5); rd(5'h08, v); check("R3 count src0", v, 32'h15);
        tick(8'h02, 3); rd(5'h08, v); check("R3 unselected source", v, 32'h15);
        wr(5'h10, 32'h85);
        tick(8'hFF, 4); rd(5'h08, v); check("R3 dead source", v, 32'h15);

        // R5 / R7 / R2 sweep of every channel in own-counter mode
        wr(5'h19, 32'hFF0);
        for (int n = 0; n < 8; n++) begin
            wr(5'(8'h10 + n), 32'h80 | (n % 4));
            wr(5'(8'h08 + n), 0);
            wr(5'(n), 3 + n);
            tick(8'(1 << (n % 4)), 2 + n);
            check("R5 no early match", {31'b0, irq}, 0);
            tick(8'(1 << (n % 4)), 1);
            check("R5 irq on match", {31'b0, irq}, 1);
            rd(5'h18, v); check("R5 status bit", v, 32'(1 << (n + 4)));
            wr(5'h18, 32'(1 << (n + 4)));
            check("R11 cleared", {31'b0, irq}, 0);
            rd(5'(8'h08 + n), v); check("R5 counter at match", v, 3 + n);
        end

        // R5 enable gate
        wr(5'h19, 0);
        wr(5'h10, 32'h80); wr(5'h08, 0); wr(5'h00, 2);
        tick(8'h01, 2);
        rd(5'h18, v); check("R5 disabled no status", v, 0);
        wr(5'h19, 32'hFF0);

        // R6 / R7 reset-on-match one-shot then periodic
        wr(5'h10, 32'h88); wr(5'h08, 0); wr(5'h00, 3);
        tick(8'h01, 3);
        check("R6 irq", {31'b0, irq}, 1);
        rd(5'h08, v); check("R6 counter zeroed", v, 0);
        wr(5'h18, 32'hFF0);
        tick(8'h01, 3);
        rd(5'h18, v); check("R7 one-shot silent", v, 0);
        rd(5'h08, v); check("R7 counter runs on", v, 3);
        wr(5'h10, 32'hC8); wr(5'h08, 0); wr(5'h00, 3);
        tick(8'h01, 3);
        rd(5'h18, v); check("R7 periodic first", v, 32'h10);
        wr(5'h18, 32'hFF0);
        tick(8'h01, 3);
        rd(5'h18, v); check("R7 periodic second", v, 32'h10);
        wr(5'h18, 32'hFF0);

        // R4 shared counters
        wr(5'h10, 32'h80); wr(5'h00, 32'h100);
        wr(5'h11, 0); wr(5'h09, 32'h50); wr(5'h08, 0); wr(5'h01, 2);
        tick(8'h01, 2);
        rd(5'h18, v); check("R4 ch1 shares counter0", v, 32'h20);
        wr(5'h18, 32'hFF0);
        wr(5'h14, 32'h80); wr(5'h15, 0); wr(5'h0C, 0); wr(5'h0D, 32'h30); wr(5'h05, 4);
        tick(8'h01, 4);
        rd(5'h18, v); check("R4 ch5 shares counter4", v, 32'h200);
        wr(5'h18, 32'hFF0);

        // R8 control width
        wr(5'h12, 32'hFFFF); rd(5'h12, v); check("R8 low channel 8 bits", v, 32'hFF);
        wr(5'h16, 32'hFFFF); rd(5'h16, v); check("R8 high channel 10 bits", v, 32'h3FF);
        wr(5'h12, 0);

        // R9 forced source 0
        wr(5'h16, 32'h185); wr(5'h0E, 0);
        tick(8'h01, 3); rd(5'h0E, v); check("R9 forced src0", v, 3);
        wr(5'h16, 32'h85);
        tick(8'h01, 3); rd(5'h0E, v); check("R9 dead without force", v, 3);

        // R10 snapshot
        wr(5'h17, 32'h200); wr(5'h0E, 32'h1234);
        rd(5'h0F, v); rd(5'h1A, v); check("R10 captured", v, 32'h1234);
        wr(5'h0E, 32'h55); wr(5'h17, 0);
        rd(5'h0F, v); rd(5'h1A, v); check("R10 held", v, 32'h1234);

        // R11 irq held by remaining status bit
        wr(5'h10, 32'h80); wr(5'h08, 0); wr(5'h00, 2);
        wr(5'h0C, 0); wr(5'h04, 2);
        tick(8'h01, 2);
        rd(5'h18, v); check("R11 two bits", v, 32'h110);
        wr(5'h18, 32'h010);
        check("R11 irq stays", {31'b0, irq}, 1);
        wr(5'h18, 32'h100);
        check("R11 irq drops", {31'b0, irq}, 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule